// File: doc/BRIEF.md
# Processor Status Flag Update Unit

This block owns the eight-bit processor status byte. It changes the byte when a flag-manipulation instruction executes, when an interrupt is taken, and when a saved status byte is pulled back from the stack. The decoder presents an opcode and an immediate operand together with a one-cycle execute strobe, and the new status appears after that clock edge. The arithmetic datapath, instruction fetch and the stack memory are outside this block. They only read `status` or feed `restore_val`.

In native mode all eight bits are flags. In emulation mode bits 5 and 4 are not flags: bit 4 is the break indicator and bit 5 is unused. Both read as 1 in that mode, and the masked clear and masked set instructions leave them alone. Entering emulation mode forces the two bits high.

Top module: `psr_flag_unit`

## Requirements
- R1: While `rst_n` is low, `status` is 0x34: the two mode-width bits 5 and 4 are set, interrupt-disable (bit 2) is set, and decimal (bit 3) and all other bits are clear.
- R2: The status bit positions are n=7, v=6, m=5, x=4, d=3, i=2, z=1, c=0. Every update takes effect at the rising clock edge on which its strobe is high.
- R3: With `exec_stb` high, the single-flag opcodes change only their own bit. The opcodes are 0x18 (clear c), 0x38 (set c), 0xD8 (clear d), 0xF8 (set d), 0x58 (clear i), 0x78 (set i) and 0xB8 (clear v).
- R4: No single-flag opcode sets v. Only the masked set (0xE2) and a restore can raise it.
- R5: Opcode 0xC2 clears every status bit whose operand bit is 1 and keeps every other bit.
- R6: Opcode 0xE2 sets every status bit whose operand bit is 1 and keeps every other bit.
- R7: While `emu_mode` is 1, bits 5 and 4 of `status` read 1 from the next edge on. Neither 0xC2, 0xE2 nor a restore changes them, and switching into emulation mode forces them to 1.
- R8: `irq_entry` sets i at the edge. If an instruction executes on the same edge, i still ends at 1.
- R9: `restore_en` loads `restore_val` into the whole byte, subject only to R7. It takes priority over an instruction and over `irq_entry` on the same edge.
- R10: When no strobe is high, or `exec_stb` carries any opcode other than the nine above, `status` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_stb | input | 1 | One-cycle strobe: the opcode executes at this edge |
| opcode | input | 8 | Opcode of the executing instruction |
| imm | input | 8 | Immediate operand used as the bit mask by 0xC2 and 0xE2 |
| emu_mode | input | 1 | 1 selects emulation mode |
| irq_entry | input | 1 | Interrupt taken: set the interrupt-disable flag |
| restore_en | input | 1 | Load the status byte from `restore_val` |
| restore_val | input | 8 | Status byte pulled from the stack |
| status | output | 8 | Current status byte |

## Verification
The masked clear and masked set are swept over all 256 operand masks from five starting bytes (0x00, 0xFF, 0xA5, 0x5A, 0x34), in native and in emulation mode. A mismatch in bits 5:4 therefore shows whether protection is missing in emulation mode or applied wrongly in native mode. All 256 opcode values are issued from two complementary starting bytes in both modes. This checks that each of the seven single-flag opcodes touches exactly one bit and that every other opcode changes nothing. Directed cases then put instructions, interrupt entry and restore on the same edge to fix their priority, and clear the mode-width bits in native mode before switching modes, so that a missing force on entry shows up.

// File: rtl/psr_flag_unit.sv
module psr_flag_unit #(
  parameter logic [7:0] RESET_STATUS = 8'h34
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       exec_stb,
  input  logic [7:0] opcode,
  input  logic [7:0] imm,
  input  logic       emu_mode,
  input  logic       irq_entry,
  input  logic       restore_en,
  input  logic [7:0] restore_val,
  output logic [7:0] status
);

  localparam logic [7:0] OP_CLR_C = 8'h18;
  localparam logic [7:0] OP_SET_C = 8'h38;
  localparam logic [7:0] OP_CLR_D = 8'hD8;
  localparam logic [7:0] OP_SET_D = 8'hF8;
  localparam logic [7:0] OP_CLR_I = 8'h58;
  localparam logic [7:0] OP_SET_I = 8'h78;
  localparam logic [7:0] OP_CLR_V = 8'hB8;
  localparam logic [7:0] OP_MCLR  = 8'hC2;
  localparam logic [7:0] OP_MSET  = 8'hE2;
  localparam logic [7:0] MODE_BITS = 8'h30;

  localparam int B_C = 0;
  localparam int B_I = 2;
  localparam int B_D = 3;
  localparam int B_V = 6;

  logic [7:0] sr;
  logic [7:0] mask;
  logic [7:0] op_res;
  logic [7:0] nxt;

  assign mask = emu_mode ? (imm & ~MODE_BITS) : imm;

  always_comb begin
    op_res = sr;
    unique case (opcode)
      OP_CLR_C: op_res[B_C] = 1'b0;
      OP_SET_C: op_res[B_C] = 1'b1;
      OP_CLR_D: op_res[B_D] = 1'b0;
      OP_SET_D: op_res[B_D] = 1'b1;
      OP_CLR_I: op_res[B_I] = 1'b0;
      OP_SET_I: op_res[B_I] = 1'b1;
      OP_CLR_V: op_res[B_V] = 1'b0;
      OP_MCLR:  op_res = sr & ~mask;
      OP_MSET:  op_res = sr | mask;
      default:  op_res = sr;
    endcase
  end

  always_comb begin
    if (restore_en)    nxt = restore_val;
    else if (exec_stb) nxt = op_res;
    else               nxt = sr;
    if (!restore_en && irq_entry) nxt[B_I] = 1'b1;
    if (emu_mode) nxt = nxt | MODE_BITS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= RESET_STATUS;
    else        sr <= nxt;
  end

  assign status = sr;

endmodule

// File: rtl/psr_flag_unit_chk.sv
module psr_flag_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       exec_stb,
  input logic [7:0] opcode,
  input logic [7:0] imm,
  input logic       emu_mode,
  input logic       irq_entry,
  input logic       restore_en,
  input logic [7:0] restore_val,
  input logic [7:0] status
);

  AST_SET_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb && opcode == 8'h38 && !restore_en |=> status[0]); // R3

  AST_NO_V_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    !restore_en && !(exec_stb && opcode == 8'hE2) && !status[6] |=> !status[6]); // R4

  AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb && opcode == 8'hC2 && !restore_en && !irq_entry && !emu_mode
    |=> (status & $past(imm)) == 8'h00); // R5

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb && opcode == 8'hE2 && !restore_en
    |=> (status & $past(imm)) == $past(imm)); // R6

  AST_EMU_MODE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    emu_mode |=> status[5:4] == 2'b11); // R7

  AST_IRQ_SETS_I: assert property (@(posedge clk) disable iff (!rst_n)
    irq_entry && !restore_en |=> status[2]); // R8

  AST_RESTORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    restore_en && !emu_mode |=> status == $past(restore_val)); // R9

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_stb && !irq_entry && !restore_en && !emu_mode |=> $stable(status)); // R10

endmodule

bind psr_flag_unit psr_flag_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .exec_stb(exec_stb), .opcode(opcode), .imm(imm),
  .emu_mode(emu_mode), .irq_entry(irq_entry), .restore_en(restore_en),
  .restore_val(restore_val), .status(status)
);

// File: tb/sim_psr_flag_unit.sv
module sim_psr_flag_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       exec_stb = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic [7:0] imm = 8'h00;
  logic       emu_mode = 1'b0;
  logic       irq_entry = 1'b0;
  logic       restore_en = 1'b0;
  logic [7:0] restore_val = 8'h00;
  logic [7:0] status;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  psr_flag_unit u0 (
    .clk(clk), .rst_n(rst_n), .exec_stb(exec_stb), .opcode(opcode), .imm(imm),
    .emu_mode(emu_mode), .irq_entry(irq_entry), .restore_en(restore_en),
    .restore_val(restore_val), .status(status)
  );

  function automatic logic [7:0] model(input logic [7:0] st, input logic [7:0] op,
                                       input logic [7:0] im, input logic emu);
    logic [7:0] r;
    logic [7:0] m;
    m = emu ? (im & 8'hCF) : im;
    case (op)
      8'h18: r = st & 8'hFE;
      8'h38: r = st | 8'h01;
      8'hD8: r = st & 8'hF7;
      8'hF8: r = st | 8'h08;
      8'h58: r = st & 8'hFB;
      8'h78: r = st | 8'h04;
      8'hB8: r = st & 8'hBF;
      8'hC2: r = st & ~m;
      8'hE2: r = st | m;
      default: r = st;
    endcase
    if (emu) r = r | 8'h30;
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: status=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] v);
    @(negedge clk);
    restore_en = 1'b1; restore_val = v;
    @(negedge clk);
    restore_en = 1'b0;
  endtask

  task automatic run_op(input string req, input logic [7:0] st, input logic [7:0] op,
                        input logic [7:0] im, input logic emu);
    logic [7:0] base;
    emu_mode = emu;
    load(st);
    base = emu ? (st | 8'h30) : st;
    exec_stb = 1'b1; opcode = op; imm = im;
    @(negedge clk);
    exec_stb = 1'b0;
    check(req, status, model(base, op, im, emu));
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: status=%02h expected=done", status);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] starts [5];
    starts = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h34};

    // R1 reset value
    @(negedge clk);
    check("R1", status, 8'h34);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1_idle", status, 8'h34);

    // R5 R6 R7: masked clear/set sweep, both modes
    for (int e = 0; e < 2; e++)
      for (int s = 0; s < 5; s++)
        for (int m = 0; m < 256; m++) begin
          run_op(e ? "R7_R5" : "R5", starts[s], 8'hC2, m[7:0], e[0]);
          run_op(e ? "R7_R6" : "R6", starts[s], 8'hE2, m[7:0], e[0]);
        end

    // R2 R3 R4 R10: every opcode from complementary states
    for (int e = 0; e < 2; e++)
      for (int o = 0; o < 256; o++) begin
        run_op("R3_R10_lo", 8'h00, o[7:0], 8'hFF, e[0]);
        run_op("R3_R10_hi", 8'hFF, o[7:0], 8'hFF, e[0]);
      end

    // R4 clear-v only clears
    run_op("R4", 8'h00, 8'hB8, 8'h00, 1'b0);
    check("R4_v", {7'd0, status[6]}, 8'h00);

    // R2 single-flag bit positions
    run_op("R2_c", 8'h00, 8'h38, 8'h00, 1'b0);
    check("R2_c", status, 8'h01);
    run_op("R2_d", 8'h00, 8'hF8, 8'h00, 1'b0);
    check("R2_d", status, 8'h08);
    run_op("R2_i", 8'h00, 8'h78, 8'h00, 1'b0);
    check("R2_i", status, 8'h04);

    // R8 irq alone and with clear-i on the same edge
    emu_mode = 1'b0;
    load(8'h00);
    irq_entry = 1'b1;
    @(negedge clk);
    irq_entry = 1'b0;
    check("R8", status, 8'h04);
    load(8'h04);
    irq_entry = 1'b1; exec_stb = 1'b1; opcode = 8'h58;
    @(negedge clk);
    irq_entry = 1'b0; exec_stb = 1'b0;
    check("R8_with_op", status, 8'h04);

    // R9 restore wins over instruction and irq
    load(8'h00);
    restore_en = 1'b1; restore_val = 8'h81; irq_entry = 1'b1;
    exec_stb = 1'b1; opcode = 8'h38;
    @(negedge clk);
    restore_en = 1'b0; irq_entry = 1'b0; exec_stb = 1'b0;
    check("R9_priority", status, 8'h81);

    // R9 R7 restore in emulation mode keeps bits 5:4
    emu_mode = 1'b1;
    load(8'h00);
    check("R9_R7_emu", status, 8'h30);

    // R7 entry forces mode bits
    emu_mode = 1'b0;
    load(8'hC3);
    check("R9_native", status, 8'hC3);
    emu_mode = 1'b1;
    @(negedge clk);
    check("R7_entry", status, 8'hF3);
    emu_mode = 1'b0;
    @(negedge clk);
    check("R10_exit", status, 8'hF3);

    // R10 idle cycles
    repeat (4) @(negedge clk);
    check("R10_idle", status, 8'hF3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule